// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two 4-bit operands with a single one-bit full adder. It spreads the addition over four cycles of a shift clock. A start strobe copies both operands into two parallel-load shift registers and seeds a carry flip-flop from the carry input. On each later clock edge the lowest bit of each operand register goes through the full adder together with the stored carry. The sum bit enters a result shift register, and the new carry replaces the stored one.

After the fourth bit step the result register holds the 4-bit sum, the carry flop holds the final carry, and a done flag rises. The sum, the carry and the done flag then hold until the next start. A start that arrives while an addition is running drops that addition and begins a new one from the new operands.

The block suits control or datapath corners where area matters more than latency. It needs one adder cell in place of a ripple chain, and it costs four cycles per result.

Top module: `bit_serial_adder`

## Requirements
- R1: While `rstN` is low, and after its release until the first start, `sumOut` is 0, `carryOut` is 0 and `done` is 0.
- R2: On a rising clock edge with `start` high, the block takes `opA`, `opB` and `carryIn`. `done` is 0 after that edge.
- R3: Bit i of the operands is added on the (i+1)-th rising edge after the start edge, LSB first. Each sum bit enters the result register at its MSB end, so that after four steps `sumOut` equals bits 3..0 of `opA + opB + carryIn`.
- R4: `done` is 0 after the first, second and third edges following the start edge. It becomes 1 after the fourth edge: exactly four bit steps per addition.
- R5: When `done` is 1, `carryOut` equals bit 4 of `opA + opB + carryIn`.
- R6: `carryIn` is sampled only on the start edge. Changing it during the four bit steps does not change the result.
- R7: While `done` is 1 and `start` is low, `sumOut`, `carryOut` and `done` hold their values whatever `opA`, `opB` and `carryIn` do.
- R8: A start during a running addition aborts it. The result then reflects only the new operands, and `done` rises four edges after the new start edge.
- R9: When `start` is held high for several edges, each of those edges reloads the block. `done` rises four edges after the last edge with `start` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; every register updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and carry, begin a new addition |
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| carryIn | input | 1 | Initial carry of the addition |
| sumOut | output | 4 | Result register contents |
| carryOut | output | 1 | Carry flop contents; final carry once `done` is 1 |
| done | output | 1 | High once the fourth bit step has finished, until the next start |

## Verification
A table of operand and carry combinations drives the main function. The table includes all-zero operands, all-ones operands with a carry in, a single operand plus a carry that ripples through every bit, and alternating bit patterns that make carries appear and vanish between steps. These patterns tell apart a wrong bit order, a carry that is not fed back, a carry seeded from the wrong source, and a result register that shifts the wrong way. Directed cases change the carry input and the operands in the middle of an addition and after completion, abort an addition midway, and hold start for several cycles. Together these show that only the start edge samples inputs, and that done rises exactly four edges after the last load.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // parallel load of operands, seed carry
    logic shift;  // one bit step through the full adder
  } bsaStrobe_t;

endpackage

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output bsaStrobe_t strobe,
  output logic       done
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] bitCnt;
  logic          busy;

  always_comb begin
    strobe.load  = start;
    strobe.shift = busy & ~start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      bitCnt <= '0;
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R2
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

  // R4
  done_after_last_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start && bitCnt == LAST) |=> done);

  // R4
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start && bitCnt != LAST) |=> !done);

endmodule

// File: rtl/bsa_fa.sv
module bsa_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end

endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bsaStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumReg,
  output logic             carryReg
);

  logic [WIDTH-1:0] aReg;
  logic [WIDTH-1:0] bReg;
  logic             sumBit;
  logic             carryNext;

  bsa_fa u_fa (
    .x  (aReg[0]),
    .y  (bReg[0]),
    .ci (carryReg),
    .s  (sumBit),
    .co (carryNext)
  );

  // Operand registers: parallel in, serial out from bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else if (strobe.load) begin
      aReg <= opA;
      bReg <= opB;
    end else if (strobe.shift) begin
      aReg <= {1'b0, aReg[WIDTH-1:1]};
      bReg <= {1'b0, bReg[WIDTH-1:1]};
    end
  end

  // Result register: serial in at the MSB, so the first bit lands at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
    end else if (strobe.shift) begin
      sumReg <= {sumBit, sumReg[WIDTH-1:1]};
    end
  end

  // Carry flop: seeded on load, fed back on every bit step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryReg <= 1'b0;
    end else if (strobe.load) begin
      carryReg <= carryIn;
    end else if (strobe.shift) begin
      carryReg <= carryNext;
    end
  end

  // R2
  load_operands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (aReg == $past(opA) && bReg == $past(opB)));

  // R6
  seed_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (carryReg == $past(carryIn)));

  // R3
  idle_holds_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> $stable(sumReg));

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             done
);

  bsaStrobe_t strobe;

  bsa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  bsa_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumReg   (sumOut),
    .carryReg (carryOut)
  );

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(sumOut) && $stable(carryOut) && done));

endmodule

// File: tb/sim_bit_serial_adder.sv
module sim_bit_serial_adder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic       carryIn = 1'b0;
  logic [3:0] sumOut;
  logic       carryOut;
  logic       done;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  bit_serial_adder u0 (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut), .done(done)
  );

  // {a, b, cin}
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [0:NVEC-1] = '{
    {4'h0, 4'h0, 1'b0},
    {4'hF, 4'hF, 1'b1},
    {4'hF, 4'h0, 1'b1},
    {4'h5, 4'hA, 1'b0},
    {4'h9, 4'h7, 1'b0},
    {4'h3, 4'hC, 1'b1},
    {4'h8, 4'h8, 1'b0},
    {4'h6, 4'h6, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic startAdd(input logic [3:0] a, input logic [3:0] b, input logic c);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [4:0] exp;
    // R1 reset state
    waitEdges(2);
    chk("R1 sum in reset", sumOut, 0);
    chk("R1 carry in reset", carryOut, 0);
    chk("R1 done in reset", done, 0);
    @(negedge clk) rstN = 1'b1;
    waitEdges(2);
    chk("R1 done after release", done, 0);
    chk("R1 sum after release", sumOut, 0);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      exp = VEC[v][8:5] + VEC[v][4:1] + VEC[v][0];
      startAdd(VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
      chk("R2 done low after start", done, 0);
      waitEdges(3);
      chk("R4 done low after 3 steps", done, 0);
      waitEdges(1);
      chk("R4 done after 4 steps", done, 1);
      chk("R3 sum", sumOut, exp[3:0]);
      chk("R5 carry out", carryOut, exp[4]);
    end

    // R7 hold after done with changing inputs
    startAdd(4'hB, 4'h6, 1'b0);  // 0x11
    waitEdges(4);
    opA = 4'h1; opB = 4'h2; carryIn = 1'b1;
    waitEdges(3);
    chk("R7 sum held", sumOut, 4'h1);
    chk("R7 carry held", carryOut, 1);
    chk("R7 done held", done, 1);

    // R6 carryIn changed mid-add is ignored
    startAdd(4'h7, 4'h0, 1'b1);  // 8
    carryIn = 1'b0;
    waitEdges(4);
    chk("R6 sum with cin seeded", sumOut, 4'h8);
    chk("R6 carry", carryOut, 0);

    // R8 abort mid-add
    startAdd(4'h1, 4'h2, 1'b0);
    waitEdges(1);
    startAdd(4'hF, 4'h1, 1'b0);  // 0x10
    chk("R8 done low after restart", done, 0);
    waitEdges(3);
    chk("R8 done low 3 after restart", done, 0);
    waitEdges(1);
    chk("R8 done", done, 1);
    chk("R8 sum", sumOut, 4'h0);
    chk("R8 carry", carryOut, 1);

    // R9 start held three edges; operands change on each
    @(negedge clk);
    opA = 4'h2; opB = 4'h2; carryIn = 1'b0; start = 1'b1;
    @(negedge clk);
    opA = 4'h4;
    @(negedge clk);
    opA = 4'hC; opB = 4'h5; carryIn = 1'b1;  // 0x12
    @(negedge clk);
    start = 1'b0;
    waitEdges(3);
    chk("R9 done low 3 after last start", done, 0);
    waitEdges(1);
    chk("R9 done", done, 1);
    chk("R9 sum", sumOut, 4'h2);
    chk("R9 carry", carryOut, 1);

    // R1 reset mid-operation clears
    startAdd(4'hF, 4'hF, 1'b1);
    waitEdges(4);
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    chk("R1 sum after reset", sumOut, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 carry after reset", carryOut, 0);

    finishRun();
  end

endmodule